// File: doc/BRIEF.md
# Interrupt and Controller Status Unit

This unit keeps the controller status word, the interrupt status word and two system configuration words of a flash memory controller. Command execution happens elsewhere: the executing logic reports each finished operation with one-cycle completion pulses and error pulses, and this unit turns them into sticky status bits, a master interrupt bit and an interrupt line whose polarity is chosen by a configuration bit.

Software clears the interrupt word by writing an AND mask. When that write leaves the master bit clear, every error flag in the status word is wiped at the same time. While the master bit is set, command writes are refused. The accept strobe tells the command logic whether a write is taken. A command write that is taken but carries an unknown code is flagged as a command error. A cold reset comes from `rst` and a warm reset from `warm_rst`. The two differ only in the completion bit that the interrupt word reports.

Top module: `irq_status_unit`

## Requirements
- R1: After a cold reset (`rst` high for a cycle), the configuration-1 word is 0x40C0, the configuration-2 word is 0x0000, the status word is 0x0000, the interrupt word is 0x8080 and `rdy` is 1.
- R2: A `warm_rst` pulse gives the same state as R1, except that the interrupt word becomes 0x8010. It takes priority over every other input in that cycle.
- R3: A pulse on `done_i[k]` (k=0 reset, 1 erase, 2 program, 3 load) sets interrupt bit 4+k and master bit 15 on the next clock edge.
- R4: A pulse on `err_i[k]` (k=0 command, 1 erase, 2 program, 3 load) sets status bit 10+k and interrupt bit 15. Status bits stay set until R6 clears them.
- R5: A register write with `wr_sel`=2 replaces the interrupt word with its current value ANDed with `wr_data`.
- R6: When an interrupt-word write leaves bit 15 clear, status bits 10 to 13 are cleared in the same edge.
- R7: When a completion or error pulse coincides with an interrupt-word write, the bits set by the pulse survive the mask. If this keeps bit 15 set, the error flags are not cleared.
- R8: `cmd_accept` is `cmd_wr` gated by interrupt bit 15 being clear, with no register stage. A refused command write changes neither the status word nor the interrupt word.
- R9: An accepted command write with `cmd_known` low sets status bit 10 and interrupt bit 15.
- R10: `irq` equals interrupt bit 15 XOR the inverse of configuration-1 bit 6.
- R11: `rd_data` presents, one cycle after `rd_sel` is applied, the word it selects: 0 is configuration 1 masked with 0xFFE0, 1 is configuration 2 in full, 2 is the interrupt word and 3 is the status word. Writes with `wr_sel`=0 and 1 load configurations 1 and 2. Writes with `wr_sel`=3 have no effect.
- R12: A write to configuration 1 sets `rdy` to bit 7 of the written value from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| warm_rst | input | 1 | Synchronous warm reset pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 cfg1, 1 cfg2, 2 interrupt mask, 3 none |
| wr_data | input | 16 | Write value |
| rd_sel | input | 2 | Read target: 0 cfg1, 1 cfg2, 2 interrupt, 3 status |
| rd_data | output | 16 | Registered read data |
| done_i | input | 4 | Completion pulses: reset, erase, program, load |
| err_i | input | 4 | Error pulses: command, erase, program, load |
| cmd_wr | input | 1 | Command write attempt |
| cmd_known | input | 1 | The attempted command code is recognised |
| cmd_accept | output | 1 | The command write is taken |
| irq | output | 1 | Interrupt line, polarity from cfg1 bit 6 |
| rdy | output | 1 | Ready line |

## Verification
The assertions assume that the completion and error pulses are single-cycle events, and that the command logic raises them only for work it has started. They also assume that `cmd_known` is meaningful only while `cmd_wr` is high. The stimulus drives every input for exactly one cycle per step and returns it to idle. It raises pulses at the same time as a mask write only where the coincidence rule is under test. It never asserts `warm_rst` together with a register write, except in the case that checks the priority of the warm reset.

// File: rtl/irqsu_pkg.sv
package irqsu_pkg;
  localparam int WORD_W = 16;
  localparam int NUM_EVT = 4;

  localparam int INT_DONE_LSB = 4;
  localparam int INT_MASTER = 15;
  localparam int ST_ERR_LSB = 10;
  localparam int CFG1_POL_BIT = 6;
  localparam int CFG1_RDY_BIT = 7;

  localparam logic [WORD_W-1:0] CFG1_RST = 16'h40C0;
  localparam logic [WORD_W-1:0] CFG2_RST = 16'h0000;
  localparam logic [WORD_W-1:0] INT_COLD = 16'h8080;
  localparam logic [WORD_W-1:0] INT_WARM = 16'h8010;
  localparam logic [WORD_W-1:0] CFG1_RDMASK = 16'hFFE0;
  localparam logic [WORD_W-1:0] ST_ERR_MASK = 16'h3C00;

  typedef enum logic [1:0] {
    SEL_CFG1 = 2'd0,
    SEL_CFG2 = 2'd1,
    SEL_INT  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqsu_cfg_regs.sv
module irqsu_cfg_regs
  import irqsu_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         warm_rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cfg1_q,
  output logic [W-1:0] cfg2_q,
  output logic         rdy_q
);
  always_ff @(posedge clk) begin
    if (rst || warm_rst) begin
      cfg1_q <= CFG1_RST;
      cfg2_q <= CFG2_RST;
      rdy_q  <= 1'b1;
    end else if (wr_en) begin
      if (wr_sel == SEL_CFG1) begin
        cfg1_q <= wr_data;
        rdy_q  <= wr_data[CFG1_RDY_BIT];
      end
      if (wr_sel == SEL_CFG2) cfg2_q <= wr_data;
    end
  end
endmodule

// File: rtl/irqsu_event_regs.sv
module irqsu_event_regs
  import irqsu_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = NUM_EVT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         warm_rst,
  input  logic         int_wr,
  input  logic [W-1:0] wr_data,
  input  logic [N-1:0] done_i,
  input  logic [N-1:0] err_i,
  input  logic         cmd_bad,
  output logic [W-1:0] int_q,
  output logic [W-1:0] stat_q
);
  logic [W-1:0] int_set, st_set, int_nx, stat_nx;
  logic         any_evt;

  assign any_evt = (|done_i) | (|err_i) | cmd_bad;

  always_comb begin
    int_set = '0;
    st_set  = '0;
    for (int k = 0; k < N; k++) begin
      int_set[INT_DONE_LSB+k] = done_i[k];
      st_set[ST_ERR_LSB+k]    = err_i[k];
    end
    st_set[ST_ERR_LSB]  = st_set[ST_ERR_LSB] | cmd_bad;
    int_set[INT_MASTER] = any_evt;
    int_nx = (int_wr ? (int_q & wr_data) : int_q) | int_set;
    if (int_wr && !int_nx[INT_MASTER])
      stat_nx = (stat_q & ~ST_ERR_MASK) | st_set;
    else
      stat_nx = stat_q | st_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q  <= INT_COLD;
      stat_q <= '0;
    end else if (warm_rst) begin
      int_q  <= INT_WARM;
      stat_q <= '0;
    end else begin
      int_q  <= int_nx;
      stat_q <= stat_nx;
    end
  end
endmodule

// File: rtl/irqsu_rd_mux.sv
module irqsu_rd_mux
  import irqsu_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   rd_sel,
  input  logic [W-1:0] cfg1_q,
  input  logic [W-1:0] cfg2_q,
  input  logic [W-1:0] int_q,
  input  logic [W-1:0] stat_q,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] rd_nx;

  always_comb begin
    unique case (rd_sel)
      SEL_CFG1: rd_nx = cfg1_q & CFG1_RDMASK;
      SEL_CFG2: rd_nx = cfg2_q;
      SEL_INT:  rd_nx = int_q;
      default:  rd_nx = stat_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nx;
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irqsu_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = NUM_EVT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         warm_rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data,
  input  logic [N-1:0] done_i,
  input  logic [N-1:0] err_i,
  input  logic         cmd_wr,
  input  logic         cmd_known,
  output logic         cmd_accept,
  output logic         irq,
  output logic         rdy
);
  logic [W-1:0] cfg1_q, cfg2_q, int_q, stat_q;
  logic         int_wr, cmd_bad;

  assign cmd_accept = cmd_wr & ~int_q[INT_MASTER];
  assign cmd_bad    = cmd_accept & ~cmd_known;
  assign int_wr     = wr_en && (wr_sel == SEL_INT);
  assign irq        = int_q[INT_MASTER] ^ ~cfg1_q[CFG1_POL_BIT];

  irqsu_cfg_regs #(.W(W)) u_cfg (
    .clk(clk), .rst(rst), .warm_rst(warm_rst), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data),
    .cfg1_q(cfg1_q), .cfg2_q(cfg2_q), .rdy_q(rdy)
  );

  irqsu_event_regs #(.W(W), .N(N)) u_evt (
    .clk(clk), .rst(rst), .warm_rst(warm_rst), .int_wr(int_wr),
    .wr_data(wr_data), .done_i(done_i), .err_i(err_i), .cmd_bad(cmd_bad),
    .int_q(int_q), .stat_q(stat_q)
  );

  irqsu_rd_mux #(.W(W)) u_rd (
    .clk(clk), .rst(rst), .rd_sel(rd_sel),
    .cfg1_q(cfg1_q), .cfg2_q(cfg2_q), .int_q(int_q), .stat_q(stat_q),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/irqsu_chk.sv
module irqsu_chk
  import irqsu_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = NUM_EVT
) (
  input logic         clk,
  input logic         rst,
  input logic         warm_rst,
  input logic         wr_en,
  input logic [1:0]   wr_sel,
  input logic [W-1:0] wr_data,
  input logic [N-1:0] done_i,
  input logic [N-1:0] err_i,
  input logic         cmd_wr,
  input logic         cmd_known,
  input logic         rdy,
  input logic [W-1:0] int_q,
  input logic [W-1:0] stat_q
);
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (rst)
    (!warm_rst && done_i != '0) |=> (int_q[INT_MASTER] &&
      ((int_q[INT_DONE_LSB +: N] & $past(done_i)) == $past(done_i)))); // R3

  AST_ERR_WIPE: assert property (@(posedge clk) disable iff (rst)
    (!warm_rst && wr_en && wr_sel == SEL_INT && !wr_data[INT_MASTER] &&
     done_i == '0 && err_i == '0 && !cmd_wr) |=> ((stat_q & ST_ERR_MASK) == '0)); // R6

  AST_CMD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!warm_rst && int_q[INT_MASTER] && cmd_wr && !cmd_known && err_i == '0 &&
     !(wr_en && wr_sel == SEL_INT)) |=> $stable(stat_q)); // R8

  AST_RDY_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (!warm_rst && wr_en && wr_sel == SEL_CFG1) |=> (rdy == $past(wr_data[CFG1_RDY_BIT]))); // R12

  AST_WARM_STATE: assert property (@(posedge clk) disable iff (rst)
    warm_rst |=> (int_q == INT_WARM && stat_q == '0 && rdy)); // R2
endmodule

bind irq_status_unit irqsu_chk #(.W(W), .N(N)) u_chk (
  .clk(clk), .rst(rst), .warm_rst(warm_rst), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .done_i(done_i), .err_i(err_i), .cmd_wr(cmd_wr),
  .cmd_known(cmd_known), .rdy(rdy), .int_q(int_q), .stat_q(stat_q)
);

// File: tb/sim_irq_status_unit.sv
`timescale 1ns/1ps
module sim_irq_status_unit;
  logic clk = 1'b0;
  logic rst = 1'b1, warm_rst = 1'b0, wr_en = 1'b0, cmd_wr = 1'b0, cmd_known = 1'b0;
  logic [1:0] wr_sel = 2'd0, rd_sel = 2'd0;
  logic [15:0] wr_data = 16'h0, rd_data;
  logic [3:0] done_i = 4'h0, err_i = 4'h0;
  logic cmd_accept, irq, rdy;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  irq_status_unit u0 (
    .clk(clk), .rst(rst), .warm_rst(warm_rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .done_i(done_i),
    .err_i(err_i), .cmd_wr(cmd_wr), .cmd_known(cmd_known),
    .cmd_accept(cmd_accept), .irq(irq), .rdy(rdy)
  );

  // vector: wr_en, wr_sel, wr_data, done, err, cmd_wr, cmd_known, exp_int, exp_stat
  typedef struct packed {
    logic        we;
    logic [1:0]  sel;
    logic [15:0] dat;
    logic [3:0]  dn;
    logic [3:0]  er;
    logic        cw;
    logic        ck;
    logic [15:0] e_int;
    logic [15:0] e_st;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd2, 16'h0000, 4'h0, 4'h0, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R5 clear
    '{1'b0, 2'd0, 16'h0000, 4'h8, 4'h0, 1'b0, 1'b0, 16'h8080, 16'h0000}, // R3 load done
    '{1'b0, 2'd0, 16'h0000, 4'h0, 4'h0, 1'b1, 1'b0, 16'h8080, 16'h0000}, // R8 blocked
    '{1'b0, 2'd0, 16'h0000, 4'h4, 4'h4, 1'b0, 1'b0, 16'h80C0, 16'h1000}, // R4 prog err
    '{1'b1, 2'd2, 16'h7FFF, 4'h0, 4'h0, 1'b0, 1'b0, 16'h00C0, 16'h0000}, // R6 wipe
    '{1'b1, 2'd2, 16'h0000, 4'h0, 4'h0, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R5
    '{1'b0, 2'd0, 16'h0000, 4'h0, 4'h0, 1'b1, 1'b0, 16'h8000, 16'h0400}, // R9 unknown
    '{1'b1, 2'd2, 16'h8000, 4'h0, 4'h0, 1'b0, 1'b0, 16'h8000, 16'h0400}, // R6 master kept
    '{1'b1, 2'd2, 16'h0000, 4'h2, 4'h0, 1'b0, 1'b0, 16'h8020, 16'h0400}, // R7 done wins
    '{1'b1, 2'd2, 16'h0000, 4'h0, 4'h0, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R6
    '{1'b0, 2'd0, 16'h0000, 4'h0, 4'h0, 1'b1, 1'b1, 16'h0000, 16'h0000}, // R8 known accepted
    '{1'b0, 2'd0, 16'h0000, 4'h8, 4'h8, 1'b0, 1'b0, 16'h8080, 16'h2000}, // R4 load err
    '{1'b1, 2'd3, 16'h0000, 4'h0, 4'h0, 1'b0, 1'b0, 16'h8080, 16'h2000}  // R11 status write ignored
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_sel = 0; wr_data = 0; done_i = 0; err_i = 0;
    cmd_wr = 0; cmd_known = 0; warm_rst = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] v);
    rd_sel = s;
    @(posedge clk); @(negedge clk);
    v = rd_data;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v;
    repeat (2) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(2'd0, v); chk("R1 cfg1", v, 16'h40C0);
    rd(2'd1, v); chk("R1 cfg2", v, 16'h0000);
    rd(2'd2, v); chk("R1 int", v, 16'h8080);
    rd(2'd3, v); chk("R1 stat", v, 16'h0000);
    chk("R1 rdy", {15'b0, rdy}, 16'h0001);
    chk("R10 irq reset", {15'b0, irq}, 16'h0001);

    for (int i = 0; i < NV; i++) begin
      wr_en = VECS[i].we; wr_sel = VECS[i].sel; wr_data = VECS[i].dat;
      done_i = VECS[i].dn; err_i = VECS[i].er;
      cmd_wr = VECS[i].cw; cmd_known = VECS[i].ck;
      @(posedge clk); @(negedge clk);
      idle();
      rd(2'd2, v); chk($sformatf("R3-vec%0d int", i), v, VECS[i].e_int);
      rd(2'd3, v); chk($sformatf("R4-vec%0d stat", i), v, VECS[i].e_st);
    end

    // R8 accept strobe gating (master currently set)
    cmd_wr = 1; #0.5;
    chk("R8 accept blocked", {15'b0, cmd_accept}, 16'h0000);
    idle();
    wr_en = 1; wr_sel = 2'd2; wr_data = 16'h0000;
    @(posedge clk); @(negedge clk); idle();
    cmd_wr = 1; #0.5;
    chk("R8 accept open", {15'b0, cmd_accept}, 16'h0001);
    idle();

    // R11 cfg1 mask, R12 rdy, R10 polarity
    wr_en = 1; wr_sel = 2'd0; wr_data = 16'h001F;
    @(posedge clk); @(negedge clk); idle();
    rd(2'd0, v); chk("R11 cfg1 mask", v, 16'h0000);
    chk("R12 rdy low", {15'b0, rdy}, 16'h0000);
    chk("R10 irq inverted idle", {15'b0, irq}, 16'h0001);
    done_i = 4'h1;
    @(posedge clk); @(negedge clk); idle();
    chk("R10 irq inverted active", {15'b0, irq}, 16'h0000);
    wr_en = 1; wr_sel = 2'd0; wr_data = 16'hFFFF;
    @(posedge clk); @(negedge clk); idle();
    rd(2'd0, v); chk("R11 cfg1 mask high", v, 16'hFFE0);
    chk("R12 rdy high", {15'b0, rdy}, 16'h0001);
    chk("R10 irq normal active", {15'b0, irq}, 16'h0001);
    wr_en = 1; wr_sel = 2'd1; wr_data = 16'hABCD;
    @(posedge clk); @(negedge clk); idle();
    rd(2'd1, v); chk("R11 cfg2", v, 16'hABCD);

    // R2 warm reset with competing write and error
    wr_en = 1; wr_sel = 2'd0; wr_data = 16'h0000; err_i = 4'h2; warm_rst = 1;
    @(posedge clk); @(negedge clk); idle();
    rd(2'd2, v); chk("R2 int", v, 16'h8010);
    rd(2'd3, v); chk("R2 stat", v, 16'h0000);
    rd(2'd0, v); chk("R2 cfg1", v, 16'h40C0);
    rd(2'd1, v); chk("R2 cfg2", v, 16'h0000);
    chk("R2 rdy", {15'b0, rdy}, 16'h0001);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule